// File: doc/BRIEF.md
# DMA Channel Request and Trigger Gate

This block decides, for a single DMA channel, when the next unit of work may start. A unit is either a data burst or a link fetch. The block picks one hardware request line out of a wide vector using an 8-bit select field. A software request can override that choice for memory-to-memory work. The request paces either the read side or the write side of the channel.

Alongside the request path, one trigger line is chosen from a trigger vector. It is synchronised into the channel clock, and its edges are detected with a programmable polarity. A detected edge is a "hit". A hit is held in a single pending slot until a gated unit consumes it. The trigger mode decides which units are gated:
- mode 0: the first burst of a block;
- mode 1: the same as mode 0;
- mode 2: only link fetches;
- mode 3: every programmed data burst.

A second hit that arrives while the slot is still full sets a sticky overrun flag.

The data path, address generation, bus masters and the linked-list engine sit outside this block. They tell it what the next unit is (`unit_first_i`, `link_fetch_i`) and strobe `burst_start_i` when a permitted unit begins.

Top module: `dma_trig_gate`

## Requirements
- R1: After reset, `trig_pending_o` and `overrun_o` are 0.
- R2: With `cfg_sw_req_i`=0 and no trigger gating, a data unit is allowed only while `hw_req_i[cfg_req_sel_i]` is 1. The select field is 8 bits wide and is decoded as an index from 0 to 255. No other request line has any effect.
- R3: With `cfg_sw_req_i`=1, the hardware request lines are ignored. A data unit is allowed on the read port (`rd_go_o`) whatever the value of `cfg_dst_req_i`.
- R4: For a hardware-paced data unit, `cfg_dst_req_i`=0 raises `rd_go_o` and `cfg_dst_req_i`=1 raises `wr_go_o`. The two outputs are never high together.
- R5: The polarity code works as follows: 1 makes a 0→1 transition of the selected trigger a hit, and 2 makes a 1→0 transition a hit. Codes 0 and 3 mask the trigger: no hit is recorded, and no unit waits for one.
- R6: A trigger transition that is applied just after a rising clock edge shows on `trig_pending_o` after the third rising edge, and not after the second.
- R7: In trigger modes 0 and 1, a data unit with `unit_first_i`=1 needs a pending hit. A data unit with `unit_first_i`=0 does not.
- R8: In trigger mode 2, a link fetch (`link_fetch_i`=1) needs a pending hit and needs no request. Data units are not gated by the trigger.
- R9: In trigger mode 3, every data unit needs a pending hit, for both software and hardware requests.
- R10: A `burst_start_i` pulse that coincides with a go output and a unit that needs a hit clears the pending hit on the next edge. A pulse when no go output is high, or when the unit needs no hit, leaves the pending hit in place.
- R11: A hit that arrives while a hit is pending and is not being consumed sets `overrun_o`. Only reset clears it.
- R12: A link fetch is always allowed on the read port (`rd_go_o`), regardless of `cfg_dst_req_i` and `cfg_sw_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_i | input | 256 | Hardware request lines, synchronous to clk |
| trig_i | input | 64 | Trigger lines, asynchronous |
| cfg_req_sel_i | input | 8 | Index of the hardware request line to follow |
| cfg_sw_req_i | input | 1 | 1 = software request (memory to memory) |
| cfg_dst_req_i | input | 1 | 1 = the request paces the write port |
| cfg_trig_sel_i | input | 6 | Index of the trigger line |
| cfg_trig_pol_i | input | 2 | Trigger polarity code |
| cfg_trig_mode_i | input | 2 | Trigger gating granularity |
| unit_first_i | input | 1 | The next data unit is the first of a block |
| link_fetch_i | input | 1 | The next unit is a link fetch |
| burst_start_i | input | 1 | One-cycle strobe: the permitted unit has started |
| rd_go_o | output | 1 | Next unit may start on the read port |
| wr_go_o | output | 1 | Next unit may start on the write port |
| trig_pending_o | output | 1 | A trigger hit is held |
| overrun_o | output | 1 | Sticky: a hit was lost |

## Verification
A corrupted pending slot shows at once, in the same cycle, as a go output that is withheld from a gated unit or granted to it without a hit. It also shows one edge after a `burst_start_i` pulse that failed to consume the hit. A wrong synchroniser depth or a wrong edge detector moves the moment `trig_pending_o` rises away from the third edge, or makes it rise for the wrong polarity. A lost overrun state shows as `overrun_o` falling without a reset. A wrong request decode shows as a go output that follows an unselected line or appears on the wrong port.

// File: rtl/dma_tg_pkg.sv
// Package: shared encodings for the DMA channel request and trigger gate.
// Assumes: the polarity and mode codes are 2-bit configuration fields.
package dma_tg_pkg;

    typedef enum logic [1:0] {
        TPOL_MASK  = 2'd0,
        TPOL_RISE  = 2'd1,
        TPOL_FALL  = 2'd2,
        TPOL_MASK2 = 2'd3
    } trig_pol_e;

    typedef enum logic [1:0] {
        TMODE_BLOCK     = 2'd0,
        TMODE_BLOCK_ALT = 2'd1,
        TMODE_LINK      = 2'd2,
        TMODE_BURST     = 2'd3
    } trig_mode_e;

endpackage

// File: rtl/dma_tg_edge.sv
// Module: trigger line selection, synchroniser and polarity edge detector.
// Assumes: trig_i is asynchronous; SYNC_STAGES >= 2. Produces a one-cycle
// hit_o for each qualifying edge of the selected line.
module dma_tg_edge
    import dma_tg_pkg::*;
#(
    parameter int TRIG_SEL_W  = 6,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_TRIG   = 1 << TRIG_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TRIG-1:0]   trig_i,
    input  logic [TRIG_SEL_W-1:0] sel_i,
    input  logic [1:0]            pol_i,
    output logic                  hit_o
);

    logic             raw_sel;
    logic [SYNC_STAGES-1:0] sync_q;
    logic             prev_q;
    logic             cur;
    trig_pol_e        pol;

    // Pick the configured trigger line.
    assign raw_sel = trig_i[sel_i];

    // Synchroniser chain: stage 0 samples the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= raw_sel;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        // Each later stage retimes the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    assign cur = sync_q[SYNC_STAGES-1];

    // Remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Qualify the edge with the polarity code; codes 0 and 3 mask.
    always_comb begin
        pol = trig_pol_e'(pol_i);
        unique case (pol)
            TPOL_RISE: hit_o = cur & ~prev_q;
            TPOL_FALL: hit_o = ~cur & prev_q;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dma_tg_req.sv
// Module: request source selection and port routing.
// Assumes: hw_req_i is synchronous to the channel clock. Link fetches
// need no peripheral request and always use the read port.
module dma_tg_req #(
    parameter int REQ_SEL_W = 8,
    localparam int NUM_REQ  = 1 << REQ_SEL_W
) (
    input  logic [NUM_REQ-1:0]   hw_req_i,
    input  logic [REQ_SEL_W-1:0] sel_i,
    input  logic                 sw_req_i,
    input  logic                 dst_req_i,
    input  logic                 link_i,
    output logic                 req_ok_o,
    output logic                 to_wr_o
);

    // Decide whether a request is present and which port it paces.
    always_comb begin
        if (link_i) begin
            req_ok_o = 1'b1;
            to_wr_o  = 1'b0;
        end else if (sw_req_i) begin
            req_ok_o = 1'b1;
            to_wr_o  = 1'b0;
        end else begin
            req_ok_o = hw_req_i[sel_i];
            to_wr_o  = dst_req_i;
        end
    end

endmodule

// File: rtl/dma_tg_hold.sv
// Module: single-slot pending hit store with sticky overrun.
// Assumes: hit_i and consume_i are one-cycle pulses in the clk domain.
module dma_tg_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic consume_i,
    output logic pend_o,
    output logic ovr_o
);

    logic pend_q;
    logic ovr_q;

    // Set on hit, clear on consume; a new hit in the consume cycle refills.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~consume_i) | hit_i;
    end

    // Record a hit that finds the slot full and not draining.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovr_q <= 1'b0;
        else if (hit_i && pend_q && !consume_i)  ovr_q <= 1'b1;
    end

    assign pend_o = pend_q;
    assign ovr_o  = ovr_q;

endmodule

// File: rtl/dma_trig_gate.sv
// Module: top of the DMA channel request and trigger gate.
// Assumes: the engine drives unit_first_i/link_fetch_i for the next unit
// and pulses burst_start_i for one cycle when that unit starts.
module dma_trig_gate
    import dma_tg_pkg::*;
#(
    parameter int REQ_SEL_W   = 8,
    parameter int TRIG_SEL_W  = 6,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_REQ    = 1 << REQ_SEL_W,
    localparam int NUM_TRIG   = 1 << TRIG_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_REQ-1:0]    hw_req_i,
    input  logic [NUM_TRIG-1:0]   trig_i,
    input  logic [REQ_SEL_W-1:0]  cfg_req_sel_i,
    input  logic                  cfg_sw_req_i,
    input  logic                  cfg_dst_req_i,
    input  logic [TRIG_SEL_W-1:0] cfg_trig_sel_i,
    input  logic [1:0]            cfg_trig_pol_i,
    input  logic [1:0]            cfg_trig_mode_i,
    input  logic                  unit_first_i,
    input  logic                  link_fetch_i,
    input  logic                  burst_start_i,
    output logic                  rd_go_o,
    output logic                  wr_go_o,
    output logic                  trig_pending_o,
    output logic                  overrun_o
);

    logic       hit_w;
    logic       pend_w;
    logic       ovr_w;
    logic       req_ok_w;
    logic       to_wr_w;
    logic       trig_on;
    logic       need_hit;
    logic       go_w;
    logic       consume_w;
    trig_mode_e mode;

    dma_tg_edge #(
        .TRIG_SEL_W (TRIG_SEL_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .trig_i(trig_i),
        .sel_i (cfg_trig_sel_i),
        .pol_i (cfg_trig_pol_i),
        .hit_o (hit_w)
    );

    dma_tg_req #(
        .REQ_SEL_W(REQ_SEL_W)
    ) u_req (
        .hw_req_i (hw_req_i),
        .sel_i    (cfg_req_sel_i),
        .sw_req_i (cfg_sw_req_i),
        .dst_req_i(cfg_dst_req_i),
        .link_i   (link_fetch_i),
        .req_ok_o (req_ok_w),
        .to_wr_o  (to_wr_w)
    );

    dma_tg_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_w),
        .consume_i(consume_w),
        .pend_o   (pend_w),
        .ovr_o    (ovr_w)
    );

    // The trigger takes part only for the rising and falling codes.
    assign trig_on = (cfg_trig_pol_i == TPOL_RISE) || (cfg_trig_pol_i == TPOL_FALL);

    // Decide whether the next unit must wait for a hit under the current mode.
    always_comb begin
        mode = trig_mode_e'(cfg_trig_mode_i);
        unique case (mode)
            TMODE_BLOCK,
            TMODE_BLOCK_ALT: need_hit = unit_first_i & ~link_fetch_i;
            TMODE_LINK:      need_hit = link_fetch_i;
            default:         need_hit = ~link_fetch_i;
        endcase
        need_hit = need_hit & trig_on;
    end

    // Combine the request and trigger conditions and route to a port.
    assign go_w      = req_ok_w & (~need_hit | pend_w);
    assign rd_go_o   = go_w & ~to_wr_w;
    assign wr_go_o   = go_w & to_wr_w;
    assign consume_w = burst_start_i & go_w & need_hit;

    assign trig_pending_o = pend_w;
    assign overrun_o      = ovr_w;

endmodule

// File: rtl/dma_trig_gate_chk.sv
// Checker: properties of the request and trigger gate, bound to the top.
// Assumes: it sees the top's ports plus the internal hit pulse.
module dma_trig_gate_chk #(
    parameter int REQ_SEL_W = 8,
    localparam int NUM_REQ  = 1 << REQ_SEL_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_REQ-1:0]   hw_req_i,
    input logic [REQ_SEL_W-1:0] cfg_req_sel_i,
    input logic                 cfg_sw_req_i,
    input logic [1:0]           cfg_trig_pol_i,
    input logic [1:0]           cfg_trig_mode_i,
    input logic                 link_fetch_i,
    input logic                 burst_start_i,
    input logic                 rd_go_o,
    input logic                 wr_go_o,
    input logic                 trig_pending_o,
    input logic                 overrun_o,
    input logic                 hit_w
);

    // R4: never both ports
    a_r4_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_go_o, wr_go_o}));

    // R2: a hardware-paced data unit needs its selected line
    a_r2_req_needed: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_go_o || wr_go_o) && !cfg_sw_req_i && !link_fetch_i) |-> hw_req_i[cfg_req_sel_i]);

    // R11: overrun is sticky
    a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    // R5: masked polarity never gates a software data unit
    a_r5_mask_open: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_trig_pol_i == 2'd0 || cfg_trig_pol_i == 2'd3) && cfg_sw_req_i && !link_fetch_i) |-> rd_go_o);

    // R8: in link mode data units are ungated
    a_r8_data_free: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_trig_mode_i == 2'd2 && cfg_sw_req_i && !link_fetch_i) |-> rd_go_o);

    // R12: link fetch always on the read port
    a_r12_link_read: assert property (@(posedge clk) disable iff (!rst_n)
        link_fetch_i |-> !wr_go_o);

    // R10: a gated burst start with no fresh hit empties the slot
    a_r10_consume: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_trig_pol_i == 2'd1 || cfg_trig_pol_i == 2'd2) && cfg_trig_mode_i == 2'd3
         && !link_fetch_i && burst_start_i && rd_go_o && !hit_w) |=> !trig_pending_o);

    // R9: in burst mode a data unit without a pending hit is held
    a_r9_burst_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_trig_pol_i == 2'd1 || cfg_trig_pol_i == 2'd2) && cfg_trig_mode_i == 2'd3
         && !link_fetch_i && !trig_pending_o) |-> !(rd_go_o || wr_go_o));

endmodule

bind dma_trig_gate dma_trig_gate_chk #(.REQ_SEL_W(REQ_SEL_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .hw_req_i       (hw_req_i),
    .cfg_req_sel_i  (cfg_req_sel_i),
    .cfg_sw_req_i   (cfg_sw_req_i),
    .cfg_trig_pol_i (cfg_trig_pol_i),
    .cfg_trig_mode_i(cfg_trig_mode_i),
    .link_fetch_i   (link_fetch_i),
    .burst_start_i  (burst_start_i),
    .rd_go_o        (rd_go_o),
    .wr_go_o        (wr_go_o),
    .trig_pending_o (trig_pending_o),
    .overrun_o      (overrun_o),
    .hit_w          (hit_w)
);

// File: tb/dma_trig_gate_tb_top.sv
// Directed bench for the DMA channel request and trigger gate.
module dma_trig_gate_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [255:0] hw_req;
    logic [63:0]  trig;
    logic [7:0]   req_sel;
    logic         sw_req;
    logic         dst_req;
    logic [5:0]   trig_sel;
    logic [1:0]   pol;
    logic [1:0]   mode;
    logic         first;
    logic         link;
    logic         bstart;
    logic         rd_go, wr_go, pend, ovr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam int TL = 5;   // trigger line used throughout

    always #5 clk = ~clk;    // 100 MHz

    dma_trig_gate dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .hw_req_i       (hw_req),
        .trig_i         (trig),
        .cfg_req_sel_i  (req_sel),
        .cfg_sw_req_i   (sw_req),
        .cfg_dst_req_i  (dst_req),
        .cfg_trig_sel_i (trig_sel),
        .cfg_trig_pol_i (pol),
        .cfg_trig_mode_i(mode),
        .unit_first_i   (first),
        .link_fetch_i   (link),
        .burst_start_i  (bstart),
        .rd_go_o        (rd_go),
        .wr_go_o        (wr_go),
        .trig_pending_o (pend),
        .overrun_o      (ovr)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        hw_req = '0; trig = '0; req_sel = '0; sw_req = 1'b1; dst_req = 1'b0;
        trig_sel = 6'(TL); pol = 2'd0; mode = 2'd0; first = 1'b0; link = 1'b0;
        bstart = 1'b0; rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Drive the trigger line and wait until the hit would be held.
    task automatic set_trig(input logic v);
        trig[TL] = v;
        tick(3);
        settle();
    endtask

    task automatic pulse_start();
        bstart = 1'b1;
        tick(1);
        bstart = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk("R1 pending", pend, 1'b0);
        chk("R1 overrun", ovr, 1'b0);
    endtask

    task automatic t_request_select();
        do_reset();
        sw_req = 1'b0; pol = 2'd0; mode = 2'd3; req_sel = 8'd200;
        hw_req[199] = 1'b1; hw_req[201] = 1'b1; settle();
        chk("R2 neighbours only", rd_go, 1'b0);
        hw_req[200] = 1'b1; settle();
        chk("R2 selected line", rd_go, 1'b1);
        req_sel = 8'd255; hw_req = '0; hw_req[255] = 1'b1; settle();
        chk("R2 top index", rd_go, 1'b1);
        req_sel = 8'd0; settle();
        chk("R2 index 0 low", rd_go, 1'b0);
    endtask

    task automatic t_sw_and_route();
        do_reset();
        sw_req = 1'b1; dst_req = 1'b1; hw_req = '0; settle();
        chk("R3 sw read port", rd_go, 1'b1);
        chk("R3 sw not write", wr_go, 1'b0);
        sw_req = 1'b0; req_sel = 8'd7; hw_req[7] = 1'b1; settle();
        chk("R4 dst write", wr_go, 1'b1);
        chk("R4 dst write rd low", rd_go, 1'b0);
        dst_req = 1'b0; settle();
        chk("R4 src read", rd_go, 1'b1);
        chk("R4 src read wr low", wr_go, 1'b0);
    endtask

    task automatic t_polarity_and_sync();
        do_reset();
        pol = 2'd1; mode = 2'd3; sw_req = 1'b1;
        settle();
        chk("R9 held without hit", rd_go, 1'b0);
        trig[TL] = 1'b1;
        tick(2); settle();
        chk("R6 not after two edges", pend, 1'b0);
        tick(1); settle();
        chk("R6 after third edge", pend, 1'b1);
        chk("R9 go with hit", rd_go, 1'b1);
        pulse_start();
        chk("R10 consumed", pend, 1'b0);
        chk("R9 held again", rd_go, 1'b0);
        set_trig(1'b0);
        chk("R5 rise ignores fall", pend, 1'b0);
        pol = 2'd2; set_trig(1'b1);
        chk("R5 fall ignores rise", pend, 1'b0);
        set_trig(1'b0);
        chk("R5 falling hit", pend, 1'b1);
        // hardware request in burst mode also gated
        pulse_start();
        sw_req = 1'b0; req_sel = 8'd3; hw_req[3] = 1'b1; settle();
        chk("R9 hw held", rd_go, 1'b0);
    endtask

    task automatic t_mask();
        do_reset();
        mode = 2'd3; sw_req = 1'b1;
        pol = 2'd0; set_trig(1'b1); set_trig(1'b0);
        chk("R5 code0 no hit", pend, 1'b0);
        chk("R5 code0 ungated", rd_go, 1'b1);
        pol = 2'd3; set_trig(1'b1); set_trig(1'b0);
        chk("R5 code3 no hit", pend, 1'b0);
        chk("R5 code3 ungated", rd_go, 1'b1);
    endtask

    task automatic t_block_mode(input logic [1:0] m);
        do_reset();
        mode = m; pol = 2'd1; sw_req = 1'b1; first = 1'b1; settle();
        chk("R7 first held", rd_go, 1'b0);
        first = 1'b0; settle();
        chk("R7 later ungated", rd_go, 1'b1);
        set_trig(1'b1);
        pulse_start();
        chk("R10 ungated start keeps hit", pend, 1'b1);
        first = 1'b1; settle();
        chk("R7 first with hit", rd_go, 1'b1);
        pulse_start();
        chk("R10 first consumes", pend, 1'b0);
    endtask

    task automatic t_link_mode();
        do_reset();
        mode = 2'd2; pol = 2'd1; sw_req = 1'b0; dst_req = 1'b1; hw_req = '0;
        link = 1'b1; settle();
        chk("R8 link held", rd_go, 1'b0);
        pulse_start();
        chk("R10 start without go keeps slot", pend, 1'b0);
        set_trig(1'b1);
        chk("R8 link with hit, no request", rd_go, 1'b1);
        chk("R12 link not write", wr_go, 1'b0);
        pulse_start();
        chk("R10 link consumes", pend, 1'b0);
        link = 1'b0; sw_req = 1'b1; settle();
        chk("R8 data ungated", rd_go, 1'b1);
        mode = 2'd3; pol = 2'd0; link = 1'b1; sw_req = 1'b0; settle();
        chk("R12 link read in other mode", rd_go, 1'b1);
    endtask

    task automatic t_overrun();
        do_reset();
        mode = 2'd3; pol = 2'd1; sw_req = 1'b1;
        set_trig(1'b1);
        chk("R11 first hit held", pend, 1'b1);
        chk("R11 no overrun yet", ovr, 1'b0);
        set_trig(1'b0);
        set_trig(1'b1);
        chk("R11 overrun set", ovr, 1'b1);
        pulse_start();
        tick(4); settle();
        chk("R11 overrun sticky", ovr, 1'b1);
        do_reset(); settle();
        chk("R11 reset clears", ovr, 1'b0);
    endtask

    initial begin
        t_reset();
        t_request_select();
        t_sw_and_route();
        t_polarity_and_sync();
        t_mask();
        t_block_mode(2'd0);
        t_block_mode(2'd1);
        t_link_mode();
        t_overrun();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule